// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator

This block produces three basic pulse-width-modulated phase levels from a single shared up/down carrier counter, so that the three pulses are centred on the same point of the carrier. A cycle setting fixes the turning point of the counter. One compare setting per phase fixes how long that phase stays active in each carrier period. The block is meant to feed a later stage, such as dead-time insertion or a converter trigger. For that stage it also raises a one-cycle pulse at the top (crest) and at the bottom (trough) of the carrier.

Settings are loaded through a single write port into pending buffers. While the generator runs, the buffered values reach the counter and the comparators only at a trough turnaround. That turnaround is the boundary between carrier periods, so no period mixes old and new settings. While the enable input is low, the buffers pass through at once, the counter rests at zero, and every output is inactive.

Top module: `pwm3_center`

## Requirements
- R1: While `enable` is low (and during reset), all phase outputs and both event pulses are low. When `enable` is first seen high, the counter starts at 0 and counts upward. The first crest pulse appears m cycles after the first enabled cycle.
- R2: Counting up, the counter turns down after the cycle where it equals the cycle setting m. It then passes through m+1 and never exceeds m+1. The carrier period is 2×(m+1) clock cycles, for m from 2 to 65534.
- R3: Counting down, the counter turns up after the cycle where it equals 1, and it equals 0 in the next cycle. The trough pulse comes m+1 cycles after the crest pulse.
- R4: The crest pulse is high for exactly one cycle: the up-counting cycle in which the count equals m. The trough pulse is high for exactly one cycle: the down-counting cycle in which the count equals 1.
- R5: A phase output is high in a cycle when the count is below that phase's compare value. A compare value of 0 keeps the phase low for the whole period.
- R6: A compare value of m+1 or more keeps that phase high through the whole carrier period.
- R7: For a compare value c with 1 ≤ c ≤ m, the phase is high for 2c−1 cycles of each carrier period.
- R8: A write stores `wrData` in a pending buffer chosen by `wrSel`: 0 = cycle setting, 1 = phase U compare, 2 = phase V compare, 3 = phase W compare. While running, the pending values take effect only from the cycle after a trough pulse. A carrier period measured from just after one trough up to and including the next trough therefore uses one set of values. While disabled, the pending values take effect on the next cycle.
- R9: Each phase follows only its own compare value. Outputs are bit 0 = U, bit 1 = V, bit 2 = W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the carrier when high; hold it at zero when low |
| wrEn | input | 1 | Write strobe for the pending settings |
| wrSel | input | 2 | Target select: 0 cycle, 1 U, 2 V, 3 W |
| wrData | input | 16 | Value to store |
| phaseOut | output | 3 | Basic phase levels, bit 0 = U, bit 1 = V, bit 2 = W |
| crestPulse | output | 1 | One-cycle pulse at the top of the carrier |
| troughPulse | output | 1 | One-cycle pulse at the bottom turnaround |

## Verification
The assertions check every cycle that the outputs are quiet while disabled and that the count never passes m+1. They also check the turn at the crest and the return to zero after a trough, that both event pulses last one cycle, that a full-scale compare holds its phase high, and that the cycle setting in use changes only after a trough. Whole-period properties cannot be seen in a single cycle: the 2×(m+1) period length, the 2c−1 high time, the delay from enable to the first crest, and settings written mid-period waiting for the boundary. Only the bench scenarios show these, by measuring trough-to-trough windows against its own model.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clear;      // hold counter at zero, pass pending settings through
    logic countUp;    // step direction of the counter
    logic load;       // copy pending settings into the active set
    logic crest;      // top of carrier this cycle
    logic trough;     // bottom turnaround this cycle
  } pwm_ctrl_t;

  // conditions reported by the datapath to the control
  typedef struct packed {
    logic atCycle;    // count equals active cycle setting
    logic atOne;      // count equals one
  } pwm_stat_t;

  localparam int unsigned SEL_CYCLE = 0;

endpackage

// File: rtl/pwm3_ctrl.sv
module pwm3_ctrl
  import pwm3_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  pwm_stat_t stat,
  output pwm_ctrl_t ctrl
);

  logic dirUp;
  logic crestNow;
  logic troughNow;

  assign crestNow  = enable &&  dirUp && stat.atCycle;
  assign troughNow = enable && !dirUp && stat.atOne;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirUp <= 1'b1;
    end else if (!enable) begin
      dirUp <= 1'b1;
    end else if (crestNow) begin
      dirUp <= 1'b0;
    end else if (troughNow) begin
      dirUp <= 1'b1;
    end
  end

  always_comb begin
    ctrl.clear   = !enable;
    ctrl.countUp = dirUp;
    ctrl.load    = !enable || troughNow;
    ctrl.crest   = crestNow;
    ctrl.trough  = troughNow;
  end

endmodule

// File: rtl/pwm3_datapath.sv
module pwm3_datapath
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PHASES  = 3,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned CYC_RST = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  pwm_ctrl_t                    ctrl,
  input  logic                         wrEn,
  input  logic [SEL_W-1:0]             wrSel,
  input  logic [CNT_W-1:0]             wrData,
  output pwm_stat_t                    stat,
  output logic [PHASES-1:0]            phaseOut,
  output logic [CNT_W-1:0]             cntVal,
  output logic [CNT_W-1:0]             actCycle,
  output logic [PHASES-1:0][CNT_W-1:0] actCmp
);

  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] CYC_INIT  = CNT_W'(CYC_RST);

  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             pendCycle;
  logic [PHASES-1:0][CNT_W-1:0] pendCmp;

  // carrier counter
  always_ff @(posedge clk) begin
    if (rst || ctrl.clear) begin
      cnt <= '0;
    end else if (ctrl.countUp) begin
      cnt <= cnt + ONE;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  // pending and active cycle setting
  always_ff @(posedge clk) begin
    if (rst) begin
      pendCycle <= CYC_INIT;
      actCycle  <= CYC_INIT;
    end else begin
      if (wrEn && (wrSel == SEL_W'(SEL_CYCLE))) begin
        pendCycle <= wrData;
      end
      if (ctrl.load) begin
        actCycle <= pendCycle;
      end
    end
  end

  // per-phase compare storage and comparison
  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(p + 1);
    logic fullOn;
    logic below;

    always_ff @(posedge clk) begin
      if (rst) begin
        pendCmp[p] <= '0;
        actCmp[p]  <= '0;
      end else begin
        if (wrEn && (wrSel == MY_SEL)) begin
          pendCmp[p] <= wrData;
        end
        if (ctrl.load) begin
          actCmp[p] <= pendCmp[p];
        end
      end
    end

    assign fullOn      = actCmp[p] > actCycle;
    assign below       = cnt < actCmp[p];
    assign phaseOut[p] = enable && (fullOn || below);
  end

  always_comb begin
    stat.atCycle = (cnt == actCycle);
    stat.atOne   = (cnt == ONE);
  end

  assign cntVal = cnt;

endmodule

// File: rtl/pwm3_center.sv
module pwm3_center
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PHASES  = 3,
  parameter int unsigned CYC_RST = 2,
  localparam int unsigned SEL_W  = $clog2(PHASES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [CNT_W-1:0]  wrData,
  output logic [PHASES-1:0] phaseOut,
  output logic              crestPulse,
  output logic              troughPulse
);

  pwm_ctrl_t                    ctrl;
  pwm_stat_t                    stat;
  logic [CNT_W-1:0]             cntVal;
  logic [CNT_W-1:0]             actCycle;
  logic [PHASES-1:0][CNT_W-1:0] actCmp;

  pwm3_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .stat   (stat),
    .ctrl   (ctrl)
  );

  pwm3_datapath #(
    .CNT_W   (CNT_W),
    .PHASES  (PHASES),
    .SEL_W   (SEL_W),
    .CYC_RST (CYC_RST)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .ctrl     (ctrl),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .stat     (stat),
    .phaseOut (phaseOut),
    .cntVal   (cntVal),
    .actCycle (actCycle),
    .actCmp   (actCmp)
  );

  assign crestPulse  = ctrl.crest;
  assign troughPulse = ctrl.trough;

endmodule

// File: rtl/pwm3_checker.sv
module pwm3_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PHASES = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         enable,
  input logic [PHASES-1:0]            phaseOut,
  input logic                         crestPulse,
  input logic                         troughPulse,
  input logic [CNT_W-1:0]             cntVal,
  input logic                         countUp,
  input logic [CNT_W-1:0]             actCycle,
  input logic [PHASES-1:0][CNT_W-1:0] actCmp
);

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (phaseOut == '0 && !crestPulse && !troughPulse));

  assert_crest_single_R4: assert property (@(posedge clk) disable iff (rst)
    crestPulse |=> !crestPulse);

  assert_trough_single_R4: assert property (@(posedge clk) disable iff (rst)
    troughPulse |=> !troughPulse);

  assert_turn_down_R2: assert property (@(posedge clk) disable iff (rst)
    crestPulse |=> (!enable || !countUp));

  assert_bound_R2: assert property (@(posedge clk) disable iff (rst)
    enable |-> ({1'b0, cntVal} <= {1'b0, actCycle} + 1'b1));

  assert_trough_zero_R3: assert property (@(posedge clk) disable iff (rst)
    troughPulse |=> (!enable || cntVal == '0));

  assert_trough_seen_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && !countUp && cntVal == CNT_W'(1)) |-> troughPulse);

  assert_shadow_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && enable && !$past(troughPulse)) |-> $stable(actCycle));

  for (genvar p = 0; p < PHASES; p++) begin : g_full
    assert_full_on_R6: assert property (@(posedge clk) disable iff (rst)
      (enable && actCmp[p] > actCycle) |-> phaseOut[p]);
  end

endmodule

bind pwm3_center pwm3_checker #(.CNT_W(CNT_W), .PHASES(PHASES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .phaseOut    (phaseOut),
  .crestPulse  (crestPulse),
  .troughPulse (troughPulse),
  .cntVal      (cntVal),
  .countUp     (ctrl.countUp),
  .actCycle    (actCycle),
  .actCmp      (actCmp)
);

// File: tb/tb_pwm3_center.sv
module tb_pwm3_center;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  phaseOut;
  logic        crestPulse;
  logic        troughPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm3_center dut (
    .clk(clk), .rst(rst), .enable(enable), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .phaseOut(phaseOut), .crestPulse(crestPulse),
    .troughPulse(troughPulse)
  );

  // behavioural reference state
  int mCnt, mUp, mPendCyc, mActCyc;
  int mPendCmp[3];
  int mActCmp[3];

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mUp = 1; mPendCyc = 2; mActCyc = 2;
      for (int i = 0; i < 3; i++) begin mPendCmp[i] = 0; mActCmp[i] = 0; end
    end else begin
      if (!enable) begin
        mCnt = 0; mUp = 1; mActCyc = mPendCyc;
        for (int i = 0; i < 3; i++) mActCmp[i] = mPendCmp[i];
      end else begin
        bit atTop, atBot;
        atTop = (mUp == 1) && (mCnt == mActCyc);
        atBot = (mUp == 0) && (mCnt == 1);
        mCnt = (mUp == 1) ? mCnt + 1 : mCnt - 1;
        if (atTop) mUp = 0;
        else if (atBot) begin
          mUp = 1; mActCyc = mPendCyc;
          for (int i = 0; i < 3; i++) mActCmp[i] = mPendCmp[i];
        end
      end
      if (wrEn) begin
        if (wrSel == 2'd0) mPendCyc = int'(wrData);
        else mPendCmp[int'(wrSel) - 1] = int'(wrData);
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison and window measurement
  int cyc = 0, lastTroughCyc = 0, lastCrestCyc = 0, lastPeriod = 0, lastCrestToTrough = 0;
  int accHigh[3];
  int lastHigh[3];
  int troughCount = 0, crestCount = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      int ePh, eCr, eTr;
      eCr = (enable && mUp == 1 && mCnt == mActCyc) ? 1 : 0;
      eTr = (enable && mUp == 0 && mCnt == 1) ? 1 : 0;
      check("R4", "crest pulse", int'(crestPulse), eCr);
      check("R3", "trough pulse", int'(troughPulse), eTr);
      for (int i = 0; i < 3; i++) begin
        ePh = (enable && (mActCmp[i] > mActCyc || mCnt < mActCmp[i])) ? 1 : 0;
        check("R5", $sformatf("phase %0d level", i), int'(phaseOut[i]), ePh);
      end
    end
    if (!enable) begin
      for (int i = 0; i < 3; i++) accHigh[i] = 0;
      lastTroughCyc = cyc;
    end else begin
      for (int i = 0; i < 3; i++) accHigh[i] += int'(phaseOut[i]);
      if (crestPulse) begin lastCrestCyc = cyc; crestCount++; end
      if (troughPulse) begin
        lastPeriod = cyc - lastTroughCyc;
        lastCrestToTrough = cyc - lastCrestCyc;
        lastTroughCyc = cyc;
        for (int i = 0; i < 3; i++) begin lastHigh[i] = accHigh[i]; accHigh[i] = 0; end
        troughCount++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] sel, input int val);
    wrEn = 1'b1; wrSel = sel; wrData = 16'(val);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic wait_troughs(input int n);
    int target;
    target = troughCount + n;
    while (troughCount < target) @(negedge clk);
    #1;
  endtask

  // enable and count cycles until the first crest
  task automatic start_and_time(input int m);
    int k;
    enable = 1'b1;
    k = 0;
    @(negedge clk);
    while (!crestPulse && k < 70000) begin @(negedge clk); k++; end
    check("R1", "cycles from enable to first crest", k, m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) tick();
    @(negedge clk);
    check("R1", "phases in reset", int'(phaseOut), 0);
    check("R1", "crest in reset", int'(crestPulse), 0);
    check("R1", "trough in reset", int'(troughPulse), 0);
    rst = 1'b0;
    tick();

    // scenario A: m=10, U=0, V=5, W=11 (full)
    wr(2'd0, 10); wr(2'd1, 0); wr(2'd2, 5); wr(2'd3, 11);
    tick();
    @(negedge clk);
    check("R1", "phases while disabled", int'(phaseOut), 0);
    tick();
    start_and_time(10);
    wait_troughs(3);
    check("R2", "carrier period m=10", lastPeriod, 22);
    check("R3", "crest to trough m=10", lastCrestToTrough, 11);
    check("R5", "U high with compare 0", lastHigh[0], 0);
    check("R7", "V high with compare 5", lastHigh[1], 9);
    check("R6", "W high with compare m+1", lastHigh[2], 22);
    check("R9", "phases differ independently", lastHigh[1] + lastHigh[2], 31);

    // scenario B: mid-period rewrite waits for the boundary
    repeat (5) tick();
    wr(2'd0, 6); wr(2'd2, 3);
    wait_troughs(1);
    check("R8", "period still old after mid write", lastPeriod, 22);
    check("R8", "V high still old after mid write", lastHigh[1], 9);
    wait_troughs(1);
    check("R8", "period uses new m=6", lastPeriod, 14);
    check("R7", "V high with compare 3", lastHigh[1], 5);
    check("R6", "W full with compare above m", lastHigh[2], 14);
    check("R9", "U unaffected", lastHigh[0], 0);

    // scenario C: disable, minimum cycle setting
    @(posedge clk); #1 enable = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R1", "phases after disable", int'(phaseOut), 0);
    end
    #1;
    wr(2'd0, 2); wr(2'd1, 1); wr(2'd2, 2); wr(2'd3, 3);
    tick();
    start_and_time(2);
    wait_troughs(2);
    check("R2", "carrier period m=2", lastPeriod, 6);
    check("R3", "crest to trough m=2", lastCrestToTrough, 3);
    check("R7", "U high with compare 1", lastHigh[0], 1);
    check("R7", "V high with compare 2", lastHigh[1], 3);
    check("R6", "W full with compare 3", lastHigh[2], 6);

    // scenario D: larger m with all phases mid-scale, write while running
    wr(2'd0, 40); wr(2'd1, 20); wr(2'd2, 1); wr(2'd3, 40);
    wait_troughs(2);
    check("R2", "carrier period m=40", lastPeriod, 82);
    check("R7", "U high with compare 20", lastHigh[0], 39);
    check("R7", "V high with compare 1", lastHigh[1], 1);
    check("R7", "W high with compare m", lastHigh[2], 79);
    check("R4", "crest count advanced", int'(crestCount > 0), 1);

    repeat (3) tick();
    finish_run();
  end

endmodule